// File: doc/BRIEF.md
# Three-Lane Seven-to-One Deserializer

This block turns three serial data lanes into a single 21-bit parallel word for each frame. It runs on a bit clock that is seven times the frame rate. It also receives the forwarded frame clock, already sampled into the bit-clock domain, and uses it to find where each word starts. Every lane shifts in seven bits per frame. When a frame closes, the block moves all three lanes into the output word at once and raises a regenerated frame clock. Downstream logic can capture the word on the falling edge of that clock.

The output side is a stream with a valid flag and no ready signal. A display bus cannot stall the source, so there is no back-pressure: each word is presented for exactly one frame and then replaced. The consumer must take it within that frame, either on the falling edge of the output clock or in any cycle in which the valid flag is high. The flag goes high only after a run of well-spaced frames. A misplaced or missing frame edge drops the frame and clears the flag. An active-low shutdown input clears every register and gates the output clock.

Top module: `tri_lane_deser`

## Requirements
- R1: Lane k (k = 0, 1, 2) carries word bits 7k through 7k+6. Within a frame each lane sends its highest-index bit first, so the first serial bit of lane k is bit 7k+6 and the seventh is bit 7k.
- R2: A frame boundary is a bit-clock cycle in which `frm_clk_s` is 1 and was 0 in the previous cycle. The lane bits sampled in that cycle are the first bits of the new frame.
- R3: At the clock edge that ends a boundary cycle lying exactly 7 cycles after the previous boundary, `word_out` loads the 21 bits received since that previous boundary. At every other edge it holds its value, except for the clear described in R8.
- R4: `out_clk` rises at the same edge as each load in R3. It stays high for 4 bit cycles and low for the remaining 3, so `word_out` does not change while `out_clk` is low or at its falling edge.
- R5: A boundary whose spacing from the previous one is not 7 cycles loads nothing and clears `word_valid`. It also forces `out_clk` low, and the block restarts its framing from that boundary.
- R6: If no boundary has arrived by the 8th cycle after the last one, `word_valid` goes low while the previous word stays held.
- R7: `word_valid` goes high together with the LOCK_FRAMES-th consecutive load (default 4) after the framing starts or restarts, and it stays high while loads keep arriving on time.
- R8: While `shdn_n` is 0, the edge that follows clears `word_out`, `out_clk`, `word_valid` and all internal state to 0, and lane data and the frame clock are ignored. After release, the first boundary only starts framing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, seven times the frame rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| shdn_n | input | 1 | Active-low shutdown and clear, synchronous |
| frm_clk_s | input | 1 | Frame clock sampled in the bit-clock domain |
| lane_in | input | 3 | Serial lanes, bit k is lane k |
| word_out | output | 21 | Recovered parallel word |
| out_clk | output | 1 | Regenerated frame clock, word stable at its fall |
| word_valid | output | 1 | Stream valid flag, no ready |

## Verification
The bench sends single-bit words at the lane edges (bits 0, 6, 7 and 20). A design that reversed the bit order or swapped lanes would put those bits in the wrong position. It sends short frames and a long stalled gap. A design that ignored the spacing would load garbage or leave stale valid words, and one without the overdue rule would keep the flag high forever. Across shutdown it checks that the outputs clear at once and that the first frame after release only starts framing. A design that only masked its outputs would show an old word after release. For every frame the bench also checks the high and low phases of the output clock, which catches a load that lands one cycle early or late.

// File: rtl/tld_pkg.sv
package tld_pkg;
  // Per-cycle outcome of the frame tracker
  typedef enum logic [2:0] {
    EV_NONE,   // no boundary this cycle
    EV_START,  // first boundary after reset or clear
    EV_GOOD,   // boundary exactly one frame after the last
    EV_DROP,   // boundary at the wrong spacing
    EV_LATE    // frame overdue, no boundary arrived
  } frm_ev_t;
endpackage

// File: rtl/tld_lane_shift.sv
module tld_lane_shift #(
  parameter int BITS = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            bit_in,
  output logic [BITS-1:0] par_out
);
  // First bit of a frame ends in the MSB after BITS shifts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   par_out <= '0;
    else if (clr) par_out <= '0;
    else          par_out <= {par_out[BITS-2:0], bit_in};
  end
endmodule

// File: rtl/tld_frame_track.sv
module tld_frame_track
  import tld_pkg::*;
#(
  parameter  int BITS = 7,
  localparam int CW   = $clog2(BITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          fclk_s,
  output frm_ev_t       ev,
  output logic [CW-1:0] phase
);
  localparam logic [CW-1:0] LAST = CW'(BITS - 1);
  localparam logic [CW-1:0] SAT  = CW'(BITS);

  logic fc_q;
  logic synced;
  logic rise;

  assign rise = fclk_s & ~fc_q;

  always_comb begin
    ev = EV_NONE;
    if (rise) begin
      if (!synced)            ev = EV_START;
      else if (phase == LAST) ev = EV_GOOD;
      else                    ev = EV_DROP;
    end else if (synced && phase == LAST) begin
      ev = EV_LATE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fc_q   <= 1'b0;
      synced <= 1'b0;
      phase  <= '0;
    end else if (clr) begin
      fc_q   <= 1'b0;
      synced <= 1'b0;
      phase  <= '0;
    end else begin
      fc_q <= fclk_s;
      if (rise) begin
        phase  <= '0;
        synced <= 1'b1;
      end else if (phase != SAT) begin
        phase <= phase + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tld_word_stage.sv
module tld_word_stage
  import tld_pkg::*;
#(
  parameter  int W           = 21,
  parameter  int BITS        = 7,
  parameter  int LOCK_FRAMES = 4,
  localparam int CW          = $clog2(BITS + 1),
  localparam int LW          = $clog2(LOCK_FRAMES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  frm_ev_t       ev,
  input  logic [CW-1:0] phase,
  input  logic [W-1:0]  par_in,
  output logic [W-1:0]  word_out,
  output logic          out_clk,
  output logic          word_valid
);
  localparam int            HALF     = (BITS + 1) / 2;
  localparam logic [CW-1:0] FALL_AT  = CW'(HALF - 1);
  localparam logic [LW-1:0] LOCK_MAX = LW'(LOCK_FRAMES);

  logic [LW-1:0] lock_cnt;

  assign word_valid = (lock_cnt == LOCK_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_out <= '0;
      out_clk  <= 1'b0;
      lock_cnt <= '0;
    end else if (clr) begin
      word_out <= '0;
      out_clk  <= 1'b0;
      lock_cnt <= '0;
    end else begin
      unique case (ev)
        EV_GOOD: begin
          word_out <= par_in;
          out_clk  <= 1'b1;
          if (lock_cnt != LOCK_MAX) lock_cnt <= lock_cnt + 1'b1;
        end
        EV_START, EV_DROP, EV_LATE: begin
          out_clk  <= 1'b0;
          lock_cnt <= '0;
        end
        default: begin
          if (phase == FALL_AT) out_clk <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/tri_lane_deser.sv
module tri_lane_deser
  import tld_pkg::*;
#(
  parameter  int LANES       = 3,
  parameter  int BITS        = 7,
  parameter  int LOCK_FRAMES = 4,
  localparam int W           = LANES * BITS,
  localparam int CW          = $clog2(BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shdn_n,
  input  logic             frm_clk_s,
  input  logic [LANES-1:0] lane_in,
  output logic [W-1:0]     word_out,
  output logic             out_clk,
  output logic             word_valid
);
  logic          clr;
  logic [W-1:0]  par;
  frm_ev_t       ev;
  logic [CW-1:0] phase;

  assign clr = ~shdn_n;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    tld_lane_shift #(.BITS(BITS)) u_sh (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .bit_in  (lane_in[k]),
      .par_out (par[k*BITS +: BITS])
    );
  end

  tld_frame_track #(.BITS(BITS)) u_trk (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .fclk_s (frm_clk_s),
    .ev     (ev),
    .phase  (phase)
  );

  tld_word_stage #(.W(W), .BITS(BITS), .LOCK_FRAMES(LOCK_FRAMES)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .ev         (ev),
    .phase      (phase),
    .par_in     (par),
    .word_out   (word_out),
    .out_clk    (out_clk),
    .word_valid (word_valid)
  );
endmodule

// File: rtl/tld_chk.sv
module tld_chk #(
  parameter int W    = 21,
  parameter int BITS = 7
) (
  input logic         clk,
  input logic         rst_n,
  input logic         shdn_n,
  input logic [W-1:0] word_out,
  input logic         out_clk,
  input logic         word_valid
);
  localparam int HALF = (BITS + 1) / 2;
  localparam int HW   = $clog2(BITS + 2);

  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 hi_cnt <= '0;
    else if (!out_clk)          hi_cnt <= '0;
    else if (hi_cnt != '1)      hi_cnt <= hi_cnt + 1'b1;
  end

  a_r8_shutdown_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n |=> (word_out == '0 && !out_clk && !word_valid));

  a_r3_load_only_with_clock_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(shdn_n) && !$stable(word_out)) |-> $rose(out_clk));

  a_r4_high_phase_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    out_clk |-> (hi_cnt < HW'(HALF)));

  a_r4_word_stable_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(out_clk) && $past(shdn_n)) |-> $stable(word_out));

  a_r7_valid_rises_with_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_valid) |-> $rose(out_clk));
endmodule

bind tri_lane_deser tld_chk #(.W(W), .BITS(BITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .shdn_n     (shdn_n),
  .word_out   (word_out),
  .out_clk    (out_clk),
  .word_valid (word_valid)
);

// File: tb/sim_tri_lane_deser.sv
module sim_tri_lane_deser;
  localparam int LOCKN = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        shdn_n = 1'b1;
  logic        frm_clk_s = 1'b0;
  logic [2:0]  lane_in = '0;
  logic [20:0] word_out;
  logic        out_clk;
  logic        word_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench model state
  bit          synced = 1'b0;
  int          good = 0;
  int          prev_len = 0;
  logic [20:0] prev_w = '0;
  logic [20:0] held = '0;

  always #5 clk = ~clk;

  tri_lane_deser #(.LOCK_FRAMES(LOCKN)) u0 (
    .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .frm_clk_s(frm_clk_s),
    .lane_in(lane_in), .word_out(word_out), .out_clk(out_clk),
    .word_valid(word_valid)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic lane_bit(input logic [20:0] w, input int k, input int i);
    return w[k*7 + 6 - i];
  endfunction

  // Send one frame of len bit cycles; lane bits follow R1 for the first 7
  task automatic frame(input logic [20:0] w, input int len);
    bit    loaded = 1'b0;
    string tag;
    if (synced && prev_len == 7) begin
      held = prev_w; loaded = 1'b1;
      if (good < LOCKN) good++;
      tag = "R1 R2 R3";
    end else begin
      good = 0;
      tag = synced ? "R5" : "R2";
    end
    synced = 1'b1;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i >= 1) begin
        chk(word_out == held, tag, 32'(word_out), 32'(held));
        chk(out_clk == (loaded && i <= 4), "R4", 32'(out_clk),
            32'(loaded && i <= 4));
        if (i >= 8)
          chk(word_valid == 1'b0, "R6", 32'(word_valid), 0);
        else
          chk(word_valid == (good >= LOCKN), loaded ? "R7" : "R5",
              32'(word_valid), 32'(good >= LOCKN));
      end
      frm_clk_s = (i < (len + 1) / 2);
      for (int k = 0; k < 3; k++)
        lane_in[k] = (i < 7) ? lane_bit(w, k, i) : 1'($urandom);
    end
    prev_w = w; prev_len = len;
  endtask

  task automatic shut(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i >= 1) begin
        chk(word_out == '0, "R8", 32'(word_out), 0);
        chk(out_clk == 1'b0 && word_valid == 1'b0, "R8",
            {30'd0, out_clk, word_valid}, 0);
      end
      shdn_n = 1'b0;
      frm_clk_s = (i < n - 1) ? 1'($urandom) : 1'b0;
      lane_in = 3'($urandom);
    end
    @(negedge clk);
    chk(word_out == '0, "R8", 32'(word_out), 0);
    shdn_n = 1'b1;
    frm_clk_s = 1'b0;
    synced = 1'b0; good = 0; held = '0; prev_len = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(word_out == '0 && !out_clk && !word_valid, "R8 reset",
        {9'd0, word_out, out_clk, word_valid}, 0);
    rst_n = 1'b1;
    // directed bit-position words
    frame(21'h000001, 7);
    frame(21'h000040, 7);
    frame(21'h000080, 7);
    frame(21'h100000, 7);
    frame(21'h1FFFFF, 7);
    frame(21'h0AAAAA, 7);
    for (int f = 0; f < 30; f++) frame(21'($urandom), 7);
    frame(21'($urandom), 5);                       // short frame
    for (int f = 0; f < 10; f++) frame(21'($urandom), 7);
    frame(21'($urandom), 20);                      // overdue gap
    for (int f = 0; f < 10; f++) frame(21'($urandom), 7);
    shut(10);
    for (int f = 0; f < 10; f++) frame(21'($urandom), 7);
    for (int f = 0; f < 150; f++) begin
      int r = int'($urandom % 20);
      frame(21'($urandom), (r == 0) ? 5 : (r == 1) ? 9 : 7);
      if (f == 75) shut(6);
    end
    frame(21'($urandom), 7);
    frame(21'($urandom), 7);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end
endmodule